// File: doc/BRIEF.md
# Link Usability Check with Stuck-Receiver Recovery

This block answers one question for a link controller: is a link that claims to be up actually fit for traffic? On request it inspects a 32-bit debug status word carrying a link-up flag and a still-training flag. It also looks at the low 6 bits of a training-state word and at a receiver-valid indication from the PHY. It then produces a one-cycle result pulse that says usable or down. A link that is up and has finished training is usable at once. A link that is not up is down at once. A link that is up but still training is given a configurable settling time and then inspected again.

The second inspection looks for one failure: a receiver that is stuck in receive-lock recovery with no valid data during a move to the second signalling rate. When that is found, the block forces two receiver override bits high on top of the software-owned override value for a fixed number of cycles and then drops them again. Every other bit follows its base value. A second inspection always reports down, so the caller retries later. Only one check is in progress at a time. A request that arrives while the block is busy is held and served as soon as the block is idle again. The waiting and holding times are counted in clock cycles.

Top module: `link_chk_mon`

## Requirements
- R1: The link-up flag is bit 4 and the still-training flag is bit 29 of `link_stat`. A request sampled while idle, when it resolves at once, gives `res_vld` high for exactly the next cycle.
- R2: A request with bit 4 of `link_stat` clear gives `res_vld` with `res_usable` = 0, whatever the other bits hold.
- R3: A request with bit 4 set and bit 29 clear gives `res_vld` with `res_usable` = 1.
- R4: A request with bits 4 and 29 both set gives no result for the next WAIT_CYC-1 cycles. The result appears WAIT_CYC cycles after the time an immediate result would have appeared.
- R5: At the end of the wait, the receiver counts as stuck when `train_state` equals 6'h0D and `rx_valid` is 0. The block then drives bits 5 and 3 of `rx_ovrd` high together for exactly HOLD_CYC cycles, starting in the same cycle as the result pulse.
- R6: All bits of `rx_ovrd` other than 5 and 3 always equal `ovrd_base`, and outside a recovery hold `rx_ovrd` equals `ovrd_base` in full.
- R7: The result after a wait is always `res_usable` = 0, whether or not a recovery follows.
- R8: A request that arrives while a check is waiting or a recovery is held is not lost. It is evaluated on the current inputs only after the override bits have been released, and no result is produced during the hold.
- R9: While reset is asserted, `res_vld` is 0 and `rx_ovrd` equals `ovrd_base`.
- R10: When `train_state` is 6'h0D with `rx_valid` = 1, or is any other value with `rx_valid` = 0, no override pulse follows the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chk_req | input | 1 | Request one usability check |
| link_stat | input | 32 | Debug status word; bit 4 link up, bit 29 still training |
| train_state | input | 6 | Training-state field from the second debug word |
| rx_valid | input | 1 | PHY receiver reports valid data |
| ovrd_base | input | 16 | Software-owned receiver override value |
| res_vld | output | 1 | One-cycle result strobe |
| res_usable | output | 1 | Result: 1 usable, 0 down; valid with `res_vld` |
| rx_ovrd | output | 16 | Receiver override value sent to the PHY |

## Verification
The bench builds the block with WAIT_CYC = 5 and HOLD_CYC = 7 in place of the millisecond-scale defaults. With these values the exact wait latency and the exact hold length can be measured cycle by cycle. They also leave room for several stuck and non-stuck re-checks, and for a request that is deliberately placed inside a recovery hold, all in a short run. The defaults only change the two counter limits and the counter width, so the same sequencing is exercised.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RECOV = 2'd2
  } lcm_state_e;

  localparam int STAT_W       = 32;
  localparam int UP_BIT       = 4;
  localparam int TRAIN_BIT    = 29;
  localparam int TS_W         = 6;
  localparam logic [TS_W-1:0] STUCK_CODE = 6'h0D;
  localparam int DATA_EN_BIT  = 5;
  localparam int PLL_EN_BIT   = 3;
endpackage

// File: rtl/lcm_decode.sv
module lcm_decode
  import lcm_pkg::*;
(
  input  logic [STAT_W-1:0] link_stat,
  input  logic [TS_W-1:0]   train_state,
  input  logic              rx_valid,
  output logic              link_up,
  output logic              training,
  output logic              stuck
);
  logic unused_stat_bits;

  assign link_up  = link_stat[UP_BIT];
  assign training = link_stat[TRAIN_BIT];
  assign stuck    = (train_state == STUCK_CODE) && !rx_valid;

  assign unused_stat_bits = ^{link_stat[STAT_W-1:TRAIN_BIT+1],
                              link_stat[TRAIN_BIT-1:UP_BIT+1],
                              link_stat[UP_BIT-1:0]};
endmodule

// File: rtl/lcm_timer.sv
module lcm_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load || !zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: a countdown that is not reloaded never moves upward
  p_cnt_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/lcm_ovrd.sv
module lcm_ovrd
  import lcm_pkg::*;
#(
  parameter int OVRD_W = 16
) (
  input  logic [OVRD_W-1:0] base,
  input  logic              force_on,
  output logic [OVRD_W-1:0] ovrd
);
  for (genvar i = 0; i < OVRD_W; i++) begin : g_bit
    if (i == DATA_EN_BIT || i == PLL_EN_BIT) begin : g_forced
      assign ovrd[i] = base[i] | force_on;
    end else begin : g_pass
      assign ovrd[i] = base[i];
    end
  end
endmodule

// File: rtl/link_chk_mon.sv
module link_chk_mon
  import lcm_pkg::*;
#(
  parameter int WAIT_CYC = 50000,
  parameter int HOLD_CYC = 100000,
  parameter int OVRD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_req,
  input  logic [31:0]       link_stat,
  input  logic [5:0]        train_state,
  input  logic              rx_valid,
  input  logic [15:0]       ovrd_base,
  output logic              res_vld,
  output logic              res_usable,
  output logic [15:0]       rx_ovrd
);
  localparam int MAX_CYC = (WAIT_CYC > HOLD_CYC) ? WAIT_CYC : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
  localparam logic [OVRD_W-1:0] FORCE_MASK =
    (OVRD_W'(1) << DATA_EN_BIT) | (OVRD_W'(1) << PLL_EN_BIT);

  lcm_state_e       state_q, state_d;
  logic             pend_q, pend_d;
  logic             vld_q, vld_d;
  logic             up_q, up_d;
  logic             go;
  logic             link_up, training, stuck;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             recov;

  lcm_decode u_decode (
    .link_stat   (link_stat),
    .train_state (train_state),
    .rx_valid    (rx_valid),
    .link_up     (link_up),
    .training    (training),
    .stuck       (stuck)
  );

  lcm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign recov = (state_q == ST_RECOV);

  lcm_ovrd #(.OVRD_W(OVRD_W)) u_ovrd (
    .base     (ovrd_base),
    .force_on (recov),
    .ovrd     (rx_ovrd)
  );

  assign go = (state_q == ST_IDLE) && (chk_req || pend_q);

  // next-state process
  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    vld_d    = 1'b0;
    up_d     = up_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          pend_d = 1'b0;
          if (!link_up) begin
            vld_d = 1'b1;
            up_d  = 1'b0;
          end else if (!training) begin
            vld_d = 1'b1;
            up_d  = 1'b1;
          end else begin
            state_d  = ST_WAIT;
            tmr_load = 1'b1;
            tmr_val  = WAIT_LD;
          end
        end
      end
      ST_WAIT: begin
        if (chk_req) pend_d = 1'b1;
        if (tmr_zero) begin
          vld_d = 1'b1;
          up_d  = 1'b0;
          if (stuck) begin
            state_d  = ST_RECOV;
            tmr_load = 1'b1;
            tmr_val  = HOLD_LD;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_RECOV: begin
        if (chk_req) pend_d = 1'b1;
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      vld_q   <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      vld_q   <= vld_d;
      if (vld_d) up_q <= up_d;
    end
  end

  assign res_vld    = vld_q;
  assign res_usable = up_q;

  // R2: missing link-up flag reports down on the next cycle
  p_down_nolink_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !link_up) |=> (res_vld && !res_usable));

  // R3: up and trained reports usable on the next cycle
  p_usable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && link_up && !training) |=> (res_vld && res_usable));

  // R4: no result while the settling wait is still counting
  p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !tmr_zero) |=> !res_vld);

  // R5: both receiver override bits are high throughout a hold
  p_force_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    recov |-> (rx_ovrd[DATA_EN_BIT] && rx_ovrd[PLL_EN_BIT]));

  // R6: every other override bit follows the base value
  p_others_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_ovrd ^ ovrd_base) & ~FORCE_MASK) == '0);

  // R7: a hold always starts together with a down result
  p_recov_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov) |-> (res_vld && !res_usable));

  // R8: no result while a hold is in progress beyond its first cycle
  p_no_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (recov && $past(recov)) |-> !res_vld);
endmodule

// File: tb/tb_link_chk_mon.sv
module tb_link_chk_mon;
  localparam int W = 5;
  localparam int H = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_req;
  logic [31:0] link_stat;
  logic [5:0]  train_state;
  logic        rx_valid;
  logic [15:0] ovrd_base;
  logic        res_vld, res_usable;
  logic [15:0] rx_ovrd;

  always #10 clk = ~clk;

  link_chk_mon #(.WAIT_CYC(W), .HOLD_CYC(H)) dut (
    .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .link_stat(link_stat),
    .train_state(train_state), .rx_valid(rx_valid), .ovrd_base(ovrd_base),
    .res_vld(res_vld), .res_usable(res_usable), .rx_ovrd(rx_ovrd)
  );

  typedef struct {
    bit usable;
    int lat;
    int issue;
    bit pend;
    int need_pulses;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int pulses = 0;
  int run    = 0;
  bit others_bad = 1'b0;
  bit finished   = 1'b0;

  localparam logic [15:0] MASK = 16'h0028;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: results against the scoreboard, override pulses
  always @(negedge clk) begin
    if (rst_n) begin
      bit f;
      f = rx_ovrd[5] && rx_ovrd[3];
      if (((rx_ovrd ^ ovrd_base) & ~MASK) != 16'h0) others_bad = 1'b1;
      if (!f && rx_ovrd != ovrd_base) others_bad = 1'b1;
      if (f) run++;
      else if (run != 0) begin
        chk(run == H, "R5", "override hold length", run, H);
        pulses++;
        run = 0;
      end
      if (res_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(res_usable == e.usable, "R1", "usable result", res_usable, e.usable);
          if (e.lat > 0)
            chk(cyc - e.issue == e.lat, "R4", "result latency", cyc - e.issue, e.lat);
          if (e.pend) begin
            chk(!f, "R8", "held request served during hold", f, 0);
            chk(pulses == e.need_pulses, "R8", "pulses before held result",
                pulses, e.need_pulses);
          end
        end
      end
    end
  end

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_check(input logic [31:0] st, input logic [5:0] ts,
                          input bit rxv, input bit exp_up, input int lat,
                          input int exp_pulses, input string req);
    exp_t e;
    @(negedge clk);
    link_stat = st; train_state = ts; rx_valid = rxv; chk_req = 1'b1;
    e.usable = exp_up; e.lat = lat; e.issue = cyc; e.pend = 1'b0; e.need_pulses = 0;
    exp_q.push_back(e);
    @(negedge clk);
    chk_req = 1'b0;
    wait_empty();
    repeat (H + 3) @(negedge clk);
    chk(pulses == exp_pulses, req, "override pulse count", pulses, exp_pulses);
  endtask

  initial begin
    rst_n = 1'b0; chk_req = 1'b0; link_stat = '0; train_state = '0;
    rx_valid = 1'b1; ovrd_base = 16'hA412;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(res_vld == 1'b0, "R9", "res_vld in reset", res_vld, 0);
    chk(rx_ovrd == ovrd_base, "R9", "override in reset", rx_ovrd, ovrd_base);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: link-up bit 4 clear, training bit set
    do_check(32'h2000_0000, 6'h00, 1'b1, 1'b0, 1, 0, "R2");
    // R2: every bit but 4 set
    do_check(32'hFFFF_FFEF, 6'h0D, 1'b0, 1'b0, 1, 0, "R2");
    // R3: bit 4 only
    do_check(32'h0000_0010, 6'h00, 1'b1, 1'b1, 1, 0, "R3");
    // R3: bit 4 with noise, bit 29 clear
    do_check(32'hDFFF_FFFF, 6'h0D, 1'b0, 1'b1, 1, 0, "R3");
    // R4/R10/R7: training, other state, rx invalid -> down, no pulse
    do_check(32'h2000_0010, 6'h11, 1'b0, 1'b0, W + 1, 0, "R10");
    // R10: stuck code but rx valid -> no pulse
    do_check(32'h2000_0010, 6'h0D, 1'b1, 1'b0, W + 1, 0, "R10");
    // R5/R7: stuck -> down and one hold pulse
    do_check(32'h2000_0010, 6'h0D, 1'b0, 1'b0, W + 1, 1, "R5");
    // R6: other override bits all set
    ovrd_base = 16'hFFD7;
    do_check(32'h2000_0010, 6'h0D, 1'b0, 1'b0, W + 1, 2, "R6");
    ovrd_base = 16'h1042;

    // R8: request placed inside a hold is held and served afterwards
    begin
      exp_t e;
      @(negedge clk);
      link_stat = 32'h2000_0010; train_state = 6'h0D; rx_valid = 1'b0; chk_req = 1'b1;
      e.usable = 1'b0; e.lat = W + 1; e.issue = cyc; e.pend = 1'b0; e.need_pulses = 0;
      exp_q.push_back(e);
      @(negedge clk);
      chk_req = 1'b0;
      wait_empty();
      @(negedge clk);
      @(negedge clk);
      chk(rx_ovrd[5] && rx_ovrd[3], "R8", "hold active at second request", rx_ovrd, 16'h1042 | MASK);
      link_stat = 32'h0000_0010; chk_req = 1'b1;
      e.usable = 1'b1; e.lat = 0; e.issue = cyc; e.pend = 1'b1; e.need_pulses = 3;
      exp_q.push_back(e);
      @(negedge clk);
      chk_req = 1'b0;
      wait_empty();
      repeat (H + 3) @(negedge clk);
      chk(pulses == 3, "R8", "pulse count after held request", pulses, 3);
    end

    chk(others_bad == 1'b0, "R6", "non-forced bits follow base", others_bad, 0);
    chk(exp_q.size() == 0, "R1", "all results received", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule